// File: doc/BRIEF.md
# Host-Slave Interrupt Register Bank

This block holds the interrupt registers that a host and a slave share across a card-style I/O link. In the slave-to-host direction, eight event inputs from slave logic each set a sticky pending bit. The host reads the pending bits, clears them by writing ones, and chooses with an enable mask which of them pull the active-low, level-sensitive interrupt line. Masking a source only stops it from driving the line. Its pending bit stays as it was.

In the host-to-slave direction, the host writes ones into a doorbell byte. The slave logic sees those bits on a parallel output. Each bit stays set until the slave pulses the matching acknowledge input, and the bit then clears by itself. The host reaches all of these registers through a simple byte-addressed read/write port of the kind a single-byte command decoder produces. Reads are combinational from the current address.

Top module: `irq_regbank`

## Requirements
- R1: After reset all pending bits, all enable bits and all doorbell bits are 0, and `irq_n_o` is 1.
- R2: When bit i of `evt_i` is high at a clock edge, pending bit i is 1 after that edge. It stays 1 until it is cleared. Host address 0x058 reads the pending byte whatever the enable mask holds.
- R3: A host write to address 0x0D4 clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged. Address 0x0D4 always reads 0x00.
- R4: When an event and a clear hit the same pending bit in the same cycle, the bit ends up 1.
- R5: Address 0x0DC is a read/write enable byte. `irq_n_o` is 0 exactly when some bit is both pending and enabled. Clearing an enable bit does not change the pending bit.
- R6: A host write to address 0x08D ORs its data into the doorbell byte. Data bits of 0 clear nothing. The doorbell byte shows on `h2s_o` and reads back at 0x08D.
- R7: A high bit on `h2s_ack_i` at a clock edge clears that doorbell bit. If a host write sets the same bit in the same cycle, the bit ends up 1.
- R8: A write to the pending address 0x058 changes nothing. Addresses 0x059-0x05B, 0x0D5-0x0D7 and 0x0DD-0x0DF read 0x00 and ignore writes. Any address not named above reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | ADDR_W (9) | Host register byte address |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_wdata | input | DATA_W (8) | Host write data |
| hst_rdata | output | DATA_W (8) | Read data for `hst_addr` (combinational) |
| evt_i | input | DATA_W (8) | Slave event inputs, one per pending bit |
| irq_n_o | output | 1 | Active-low level interrupt to the host |
| h2s_o | output | DATA_W (8) | Doorbell bits presented to the slave |
| h2s_ack_i | input | DATA_W (8) | Slave acknowledge, one per doorbell bit |

## Verification
The assertions rely on the reset being applied before the first clock edge. They also rely on `hst_addr`, `hst_wr` and `hst_wdata` changing only between edges, because the clear and doorbell checks compare a bit's fall against the strobe sampled at the previous edge. The bench changes every input at the falling edge, so each sampled write lasts exactly one rising edge. The bench also drives collisions on purpose: an event together with a clear of the same bit, and an acknowledge together with a doorbell write of the same bit. A behavioural model of all three registers follows the same inputs and is compared with the outputs and with the read data on every clock.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int unsigned OFS_PEND = 'h058;
    localparam int unsigned OFS_CLR  = 'h0D4;
    localparam int unsigned OFS_MASK = 'h0DC;
    localparam int unsigned OFS_BELL = 'h08D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_CLR,
        SEL_MASK,
        SEL_BELL
    } reg_sel_e;
endpackage

// File: rtl/irqb_dec.sv
module irqb_dec
    import irqb_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_PEND)) sel = SEL_PEND;
        if (addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
        if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
        if (addr == ADDR_W'(OFS_BELL)) sel = SEL_BELL;
    end
endmodule

// File: rtl/irqb_s2h.sv
module irqb_s2h #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] mask,
    output logic         irq_n
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] mask;
    } s2h_t;

    s2h_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event is OR-ed in after the clear, so the event wins
        if (clr_we) st_d.pend = st_q.pend & ~wdata;
        st_d.pend = st_d.pend | evt;
        if (mask_we) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.pend;
    assign mask  = st_q.mask;
    assign irq_n = ~|(st_q.pend & st_q.mask);
endmodule

// File: rtl/irqb_h2s.sv
module irqb_h2s #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ack,
    output logic [W-1:0] bell
);
    logic [W-1:0] bell_d, bell_q;

    always_comb begin
        bell_d = bell_q & ~ack;
        // a host write applies after the acknowledge, so the write wins
        if (set_we) bell_d = bell_d | wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bell_q <= '0;
        else        bell_q <= bell_d;
    end

    assign bell = bell_q;
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irqb_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic [DATA_W-1:0] evt_i,
    output logic              irq_n_o,
    output logic [DATA_W-1:0] h2s_o,
    input  logic [DATA_W-1:0] h2s_ack_i
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] pend_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] bell_w;

    irqb_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (hst_addr),
        .sel  (sel)
    );

    irqb_s2h #(.W(DATA_W)) u_s2h (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr_we  (hst_wr && sel == SEL_CLR),
        .mask_we (hst_wr && sel == SEL_MASK),
        .wdata   (hst_wdata),
        .pend    (pend_w),
        .mask    (mask_w),
        .irq_n   (irq_n_o)
    );

    irqb_h2s #(.W(DATA_W)) u_h2s (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (hst_wr && sel == SEL_BELL),
        .wdata  (hst_wdata),
        .ack    (h2s_ack_i),
        .bell   (bell_w)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND: hst_rdata = pend_w;
            SEL_MASK: hst_rdata = mask_w;
            SEL_BELL: hst_rdata = bell_w;
            default:  hst_rdata = '0;
        endcase
    end

    assign h2s_o = bell_w;
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
    import irqb_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              hst_wr,
    input logic [W-1:0]      hst_wdata,
    input logic [W-1:0]      evt_i,
    input logic              irq_n_o,
    input logic [W-1:0]      h2s_o,
    input logic [W-1:0]      h2s_ack_i,
    input logic [W-1:0]      pend
);
    logic [W-1:0] prev_pend, prev_clr, prev_bell, prev_set, prev_ack;
    logic         clr_hit, bell_hit;

    assign clr_hit  = hst_wr && hst_addr == ADDR_W'(OFS_CLR);
    assign bell_hit = hst_wr && hst_addr == ADDR_W'(OFS_BELL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pend <= '0;
            prev_clr  <= '0;
            prev_bell <= '0;
            prev_set  <= '0;
            prev_ack  <= '0;
        end else begin
            prev_pend <= pend;
            prev_clr  <= clr_hit ? hst_wdata : '0;
            prev_bell <= h2s_o;
            prev_set  <= bell_hit ? hst_wdata : '0;
            prev_ack  <= h2s_ack_i;
        end
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((pend & $past(evt_i)) == $past(evt_i)));

    assert_fall_needs_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_pend & ~pend & ~prev_clr) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && (evt_i & hst_wdata) != '0)
        |=> ((pend & $past(evt_i & hst_wdata)) == $past(evt_i & hst_wdata)));

    assert_irq_has_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o) |-> (pend != '0));

    assert_bell_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((h2s_o & ~prev_bell & ~prev_set) == '0));

    assert_bell_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_bell & ~h2s_o & ~prev_ack) == '0));
endmodule

bind irq_regbank irqb_chk #(.ADDR_W(ADDR_W), .W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_addr  (hst_addr),
    .hst_wr    (hst_wr),
    .hst_wdata (hst_wdata),
    .evt_i     (evt_i),
    .irq_n_o   (irq_n_o),
    .h2s_o     (h2s_o),
    .h2s_ack_i (h2s_ack_i),
    .pend      (pend_w)
);

// File: tb/sim_irq_regbank.sv
`timescale 1ns/1ps
module sim_irq_regbank;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [8:0] hst_addr = '0;
    logic       hst_wr = 0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic [7:0] evt_i = '0;
    logic       irq_n_o;
    logic [7:0] h2s_o;
    logic [7:0] h2s_ack_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    int m_pend = 0, m_mask = 0, m_bell = 0;

    always #5 clk = ~clk;

    irq_regbank u0 (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .evt_i(evt_i),
        .irq_n_o(irq_n_o), .h2s_o(h2s_o), .h2s_ack_i(h2s_ack_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_read(input int a);
        case (a)
            'h058:   return m_pend;
            'h0DC:   return m_mask;
            'h08D:   return m_bell;
            default: return 0;
        endcase
    endfunction

    // reference model, updated at each edge, compared shortly after
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_mask = 0; m_bell = 0;
        end else begin
            if (hst_wr && hst_addr == 9'h0D4) m_pend = m_pend & ~int'(hst_wdata);
            m_pend = (m_pend | int'(evt_i)) & 'hFF;
            if (hst_wr && hst_addr == 9'h0DC) m_mask = int'(hst_wdata);
            m_bell = m_bell & ~int'(h2s_ack_i) & 'hFF;
            if (hst_wr && hst_addr == 9'h08D) m_bell = m_bell | int'(hst_wdata);
        end
        #2;
        chk("R5 irq_n_o per clock", int'(irq_n_o), ((m_pend & m_mask) != 0) ? 0 : 1);
        chk("R6 h2s_o per clock", int'(h2s_o), m_bell);
        chk("R8 hst_rdata per clock", int'(hst_rdata), m_read(int'(hst_addr)));
    end

    task automatic hwrite(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1;
        @(negedge clk);
        hst_wr = 0;
    endtask

    task automatic hread(input string req, input logic [8:0] a, input int exp);
        @(negedge clk);
        hst_addr = a;
        #1;
        chk(req, int'(hst_rdata), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        hread("R1 pending after reset", 9'h058, 0);
        hread("R1 mask after reset", 9'h0DC, 0);
        chk("R1 irq_n_o after reset", int'(irq_n_o), 1);
        chk("R1 h2s_o after reset", int'(h2s_o), 0);

        // R2 event sets sticky pending bit, masked source keeps line high
        @(negedge clk); evt_i = 8'h08;
        @(negedge clk); evt_i = 8'h00;
        hread("R2 pending sticky", 9'h058, 8'h08);
        chk("R5 masked source keeps irq high", int'(irq_n_o), 1);

        // R5 enable drives line, masking keeps pending
        hwrite(9'h0DC, 8'h08);
        #1 chk("R5 enabled source asserts irq", int'(irq_n_o), 0);
        hread("R5 mask readback", 9'h0DC, 8'h08);
        hwrite(9'h0DC, 8'h00);
        #1 chk("R5 masking releases irq", int'(irq_n_o), 1);
        hread("R5 masking keeps pending", 9'h058, 8'h08);
        hwrite(9'h0DC, 8'hFF);

        // R3 write-one-to-clear
        hwrite(9'h0D4, 8'h00);
        hread("R3 zero clear keeps bit", 9'h058, 8'h08);
        hwrite(9'h0D4, 8'h08);
        hread("R3 one clears bit", 9'h058, 8'h00);
        #1 chk("R5 cleared source releases irq", int'(irq_n_o), 1);
        hread("R3 clear address reads zero", 9'h0D4, 0);

        // R4 event and clear on the same bit in one cycle
        @(negedge clk);
        evt_i = 8'h02; hst_addr = 9'h0D4; hst_wdata = 8'h02; hst_wr = 1;
        @(negedge clk);
        evt_i = 8'h00; hst_wr = 0;
        hread("R4 set wins over clear", 9'h058, 8'h02);
        hwrite(9'h0D4, 8'hFF);
        hread("R3 clear all", 9'h058, 0);

        // R6 doorbell
        hwrite(9'h08D, 8'h05);
        #1 chk("R6 doorbell set", int'(h2s_o), 8'h05);
        hwrite(9'h08D, 8'h00);
        #1 chk("R6 zero write clears nothing", int'(h2s_o), 8'h05);
        hread("R6 doorbell readback", 9'h08D, 8'h05);

        // R7 acknowledge clears, write wins on collision
        @(negedge clk); h2s_ack_i = 8'h01;
        @(negedge clk); h2s_ack_i = 8'h00;
        #1 chk("R7 ack clears bit", int'(h2s_o), 8'h04);
        @(negedge clk);
        h2s_ack_i = 8'h04; hst_addr = 9'h08D; hst_wdata = 8'h04; hst_wr = 1;
        @(negedge clk);
        h2s_ack_i = 8'h00; hst_wr = 0;
        #1 chk("R7 write wins over ack", int'(h2s_o), 8'h04);
        @(negedge clk); h2s_ack_i = 8'h04;
        @(negedge clk); h2s_ack_i = 8'h00;
        #1 chk("R7 ack final clear", int'(h2s_o), 8'h00);

        // R8 read-only and unmapped addresses
        @(negedge clk); evt_i = 8'h30;
        @(negedge clk); evt_i = 8'h00;
        hwrite(9'h058, 8'h00);
        hread("R8 pending write ignored", 9'h058, 8'h30);
        hwrite(9'h0DD, 8'h00);
        hread("R8 upper mask byte ignored", 9'h0DC, 8'hFF);
        hread("R8 upper pending byte reads zero", 9'h059, 0);
        hwrite(9'h100, 8'hAA);
        hread("R8 unmapped reads zero", 9'h100, 0);
        #1 chk("R5 pending and enabled asserts irq", int'(irq_n_o), 0);

        // R1 reset again from a busy state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        hread("R1 pending after second reset", 9'h058, 0);
        chk("R1 irq after second reset", int'(irq_n_o), 1);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule